// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns one parallel byte into an asynchronous serial frame on a line that rests high. A six-bit line-control field sets the frame format. It selects a word length of five to eight bits, a stop length of one, one and a half or two bit times, and whether a parity bit is sent. When parity is sent, the field also selects odd, even or a fixed (stick) value for that bit.

Bit timing comes from a baud tick that pulses once per sixteenth of a bit. The block accepts a byte through a valid/ready handshake. It samples the control field in the same cycle, so a later change to the field cannot disturb a frame that is already on the line. Ready stays low for the whole frame and comes back in the cycle after the last stop tick, so a producer that holds valid high can send frames back to back.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1, `in_ready` is 0 and `txd` carries a low start bit.
- R3: Data bits follow the start bit, least significant first. The count is set by `line_ctrl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Byte bits above the selected length are never sent and do not change the parity.
- R4: The start, data and parity bits each last exactly 16 baud ticks. Clock cycles without a tick do not advance the frame.
- R5: With `line_ctrl[2]`=0 the stop interval is high for 16 ticks, at every word length.
- R6: With `line_ctrl[2]`=1 the stop interval is 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8-bit words.
- R7: With `line_ctrl[3]`=0 no parity bit is sent, and the stop interval follows the last data bit.
- R8: With `line_ctrl[3]`=1 and `line_ctrl[5]`=0, a parity bit follows the data. It makes the number of ones across data and parity odd when `line_ctrl[4]`=0 and even when `line_ctrl[4]`=1.
- R9: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit is fixed: 1 when `line_ctrl[4]`=0 and 0 when `line_ctrl[4]`=1.
- R10: The frame format and data are captured at acceptance. Changes to `line_ctrl` or `in_data` during a frame do not affect it.
- R11: `in_ready` rises in the cycle right after the clock edge that counts the last stop tick. If `in_valid` is still high, the next frame is accepted on the following edge.
- R12: When `line_ctrl[3]`=0, `line_ctrl[5]` and `line_ctrl[4]` have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| line_ctrl | input | 6 | Frame format field, captured at acceptance |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The word-length sweep uses bytes whose upper bits are set, so sending too many bits or the wrong bit order shows up as a different waveform. The parity cases use bytes with one, two and three ones under odd and even parity, together with both stick values and stick set without parity enabled. These cases tell the four parity rules apart and catch an inverted parity sense. The stop settings are run at word length 5 and at longer words, which separates 16, 24 and 32-tick stop intervals. Every frame is followed by a scrambled control field and a scrambled byte. Back-to-back sends check that ready returns one cycle after the last stop tick.

// File: rtl/aft_pkg.sv
package aft_pkg;

   // Bit positions in the line-control field (fixed by behaviour)
   localparam int CTL_LEN_LO = 0;
   localparam int CTL_LEN_HI = 1;
   localparam int CTL_STOP   = 2;
   localparam int CTL_PAR_EN = 3;
   localparam int CTL_EVEN   = 4;
   localparam int CTL_STICK  = 5;
   localparam int CTL_W      = 6;
   localparam int BYTE_W     = 8;
   localparam int MIN_WORD   = 5;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_START  = 3'd1,
      S_DATA   = 3'd2,
      S_PARITY = 3'd3,
      S_STOP   = 3'd4
   } tx_state_t;

   typedef struct packed {
      logic [2:0]        last_idx;  // index of the final data bit
      logic              par_en;
      logic              par_bit;
      logic [BYTE_W-1:0] data;      // bits above last_idx cleared
   } frame_fmt_t;

endpackage

// File: rtl/aft_fmt_decode.sv
module aft_fmt_decode
   import aft_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter bit STICK_SUPPORT = 1'b1,
   parameter int CNT_W         = 6
) (
   input  logic [CTL_W-1:0]  ctrl,
   input  logic [BYTE_W-1:0] data,
   output frame_fmt_t        fmt,
   output logic [CNT_W-1:0]  stop_ticks
);

   localparam int STOP_ONE   = TICKS_PER_BIT;
   localparam int STOP_HALF  = TICKS_PER_BIT + TICKS_PER_BIT / 2;
   localparam int STOP_TWO   = 2 * TICKS_PER_BIT;

   logic [2:0]        last_idx;
   logic [BYTE_W-1:0] masked;
   logic              even_sel;
   logic              stick_par;
   logic              calc_par;

   assign last_idx = 3'(MIN_WORD - 1) + {1'b0, ctrl[CTL_LEN_HI:CTL_LEN_LO]};
   assign even_sel = ctrl[CTL_EVEN];

   always_comb begin
      for (int i = 0; i < BYTE_W; i++) begin
         masked[i] = data[i] && (3'(i) <= last_idx);
      end
   end

   // data ones + parity bit: odd total when even_sel=0, even total when 1
   assign calc_par = even_sel ? (^masked) : ~(^masked);

   generate
      if (STICK_SUPPORT) begin : g_stick
         assign stick_par = ctrl[CTL_STICK];
      end else begin : g_no_stick
         assign stick_par = 1'b0;
      end
   endgenerate

   always_comb begin
      fmt.last_idx = last_idx;
      fmt.par_en   = ctrl[CTL_PAR_EN];
      fmt.par_bit  = stick_par ? ~even_sel : calc_par;
      fmt.data     = masked;
      if (!ctrl[CTL_STOP])
         stop_ticks = CNT_W'(STOP_ONE);
      else if (last_idx == 3'(MIN_WORD - 1))
         stop_ticks = CNT_W'(STOP_HALF);
      else
         stop_ticks = CNT_W'(STOP_TWO);
   end

endmodule

// File: rtl/aft_sequencer.sv
module aft_sequencer
   import aft_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter int CNT_W         = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             baud_tick,
   input  frame_fmt_t       fmt,
   input  logic [CNT_W-1:0] stop_ticks,
   output logic             txd,
   output logic             busy
);

   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TICKS_PER_BIT - 1);

   tx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic              bit_done;
   logic              stop_done;

   assign bit_done  = baud_tick && (cnt == BIT_LAST);
   assign stop_done = baud_tick && (cnt == stop_ticks - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               cnt <= '0;
               if (launch) state <= S_START;
            end
            S_START: begin
               if (bit_done) begin
                  cnt     <= '0;
                  state   <= S_DATA;
                  bit_idx <= '0;
                  shreg   <= fmt.data;
               end else if (baud_tick) cnt <= cnt + CNT_W'(1);
            end
            S_DATA: begin
               if (bit_done) begin
                  cnt   <= '0;
                  shreg <= shreg >> 1;
                  if (bit_idx == fmt.last_idx)
                     state <= fmt.par_en ? S_PARITY : S_STOP;
                  else
                     bit_idx <= bit_idx + 3'd1;
               end else if (baud_tick) cnt <= cnt + CNT_W'(1);
            end
            S_PARITY: begin
               if (bit_done) begin
                  cnt   <= '0;
                  state <= S_STOP;
               end else if (baud_tick) cnt <= cnt + CNT_W'(1);
            end
            S_STOP: begin
               if (stop_done) begin
                  cnt   <= '0;
                  state <= S_IDLE;
               end else if (baud_tick) cnt <= cnt + CNT_W'(1);
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         S_START:  txd = 1'b0;
         S_DATA:   txd = shreg[0];
         S_PARITY: txd = fmt.par_bit;
         default:  txd = 1'b1;
      endcase
   end

   assign busy = (state != S_IDLE);

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> ($stable(state) && $stable(cnt))); // R4
   AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != S_STOP) |-> (cnt < CNT_W'(TICKS_PER_BIT))); // R4
   AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_STOP) |-> (cnt < stop_ticks)); // R6
   AST_PARITY_ONLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PARITY) |-> fmt.par_en); // R7

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
   import aft_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter bit STICK_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        baud_tick,
   input  logic [5:0]  line_ctrl,
   input  logic [7:0]  in_data,
   input  logic        in_valid,
   output logic        in_ready,
   output logic        txd,
   output logic        busy
);

   localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

   generate
      if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be even and at least 2");
      end
   endgenerate

   frame_fmt_t       fmt_now, fmt_q;
   logic [CNT_W-1:0] stop_now, stop_q;
   logic             accept;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   aft_fmt_decode #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .STICK_SUPPORT (STICK_SUPPORT),
      .CNT_W         (CNT_W)
   ) u_decode (
      .ctrl       (line_ctrl),
      .data       (in_data),
      .fmt        (fmt_now),
      .stop_ticks (stop_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q  <= '0;
         stop_q <= CNT_W'(TICKS_PER_BIT);
      end else if (accept) begin
         fmt_q  <= fmt_now;
         stop_q <= stop_now;
      end
   end

   aft_sequencer #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .CNT_W         (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (accept),
      .baud_tick  (baud_tick),
      .fmt        (fmt_q),
      .stop_ticks (stop_q),
      .txd        (txd),
      .busy       (busy)
   );

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R1
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && !txd && !in_ready)); // R2
   AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(fmt_q) && $stable(stop_q))); // R10

endmodule

// File: tb/async_frame_tx_bench.sv
`timescale 1ns/1ps
module async_frame_tx_bench;

   typedef struct {
      logic [255:0] v;
      int           len;
      string        tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       baud_tick;
   logic [5:0] line_ctrl;
   logic [7:0] in_data;
   logic       in_valid;
   logic       in_ready, txd, busy;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   async_frame_tx u_async_frame_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .txd(txd), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // baud tick every second clock, changed just after posedge
   initial begin
      baud_tick = 1'b0;
      forever begin
         @(posedge clk);
         #1 baud_tick = ~baud_tick;
      end
   end

   // driver: builds the expected tick-by-tick line waveform and offers the byte
   task automatic send(input logic [7:0] d, input logic [5:0] c, input string tag);
      exp_t e;
      int   nb;
      int   stop;
      logic p;
      logic ones;
      e.v = '0; e.len = 0; e.tag = tag;
      nb = 5 + int'(c[1:0]);
      for (int k = 0; k < 16; k++) begin e.v[e.len] = 1'b0; e.len++; end
      ones = 1'b0;
      for (int i = 0; i < nb; i++) begin
         ones ^= d[i];
         for (int k = 0; k < 16; k++) begin e.v[e.len] = d[i]; e.len++; end
      end
      if (c[3]) begin
         if (c[5]) p = ~c[4];
         else      p = c[4] ? ones : ~ones;
         for (int k = 0; k < 16; k++) begin e.v[e.len] = p; e.len++; end
      end
      stop = !c[2] ? 16 : (nb == 5 ? 24 : 32);
      for (int k = 0; k < stop; k++) begin e.v[e.len] = 1'b1; e.len++; end
      do @(negedge clk); while (!in_ready);
      q.push_back(e);
      in_data = d; line_ctrl = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      line_ctrl = ~c;   // R10: scrambled after acceptance
      in_data = ~d;
   endtask

   // monitor: captures txd on every tick of a frame and compares
   logic [255:0] got;
   int  glen = 0;
   int  since_tick = 0;
   bit  capturing = 1'b0;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (busy) begin
            if (!capturing) begin
               capturing = 1'b1; glen = 0; got = '0;
               check(in_ready == 1'b0, "R2", "ready during frame", int'(in_ready), 0);
            end
            if (baud_tick) begin
               if (glen < 256) got[glen] = txd;
               glen++;
               since_tick = 0;
            end else since_tick++;
         end else if (capturing) begin
            exp_t e;
            capturing = 1'b0;
            check(since_tick == 0 && in_ready, "R11", "cycles after last stop tick",
                  since_tick + 1, 1);
            if (q.size() == 0) begin
               check(1'b0, "R2", "unexpected frame", glen, 0);
            end else begin
               e = q.pop_front();
               check(glen == e.len, e.tag, "frame length in ticks", glen, e.len);
               if (glen == e.len)
                  check(got == e.v, e.tag, "first mismatching tick",
                        first_diff(got, e.v), -1);
            end
         end
      end
   end

   function automatic int first_diff(input logic [255:0] a, input logic [255:0] b);
      for (int i = 0; i < 256; i++) if (a[i] !== b[i]) return i;
      return -1;
   endfunction

   initial begin
      #(8 * 150000);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; line_ctrl = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(txd == 1'b1,      "R1", "txd after reset",      int'(txd), 1);
      check(busy == 1'b0,     "R1", "busy after reset",     int'(busy), 0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

      send(8'hE5, 6'b000000, "R3 5-bit upper ignored");
      send(8'hA6, 6'b000001, "R3 6-bit");
      send(8'h3C, 6'b000010, "R3 7-bit");
      send(8'h81, 6'b000011, "R5 8-bit one stop");
      send(8'h13, 6'b000100, "R6 5-bit 1.5 stop");
      send(8'h5A, 6'b000111, "R6 8-bit 2 stop");
      send(8'h01, 6'b001011, "R8 odd one-ones");
      send(8'h03, 6'b001011, "R8 odd two-ones");
      send(8'h03, 6'b011011, "R8 even two-ones");
      send(8'hE7, 6'b011000, "R8 even 5-bit masked");
      send(8'h00, 6'b101011, "R9 stick one");
      send(8'hFF, 6'b111011, "R9 stick zero");
      send(8'h55, 6'b100010, "R12 stick without parity");
      send(8'hC3, 6'b110110, "R12 R7 7-bit 2 stop");
      send(8'h96, 6'b001111, "R11 back-to-back A");
      send(8'h69, 6'b011101, "R11 back-to-back B");

      while (q.size() != 0 || busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(txd == 1'b1 && !busy, "R1", "idle after last frame", int'(txd), 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule